// File: doc/BRIEF.md
# Packed Text Label Stream Encoder

This block turns a 16-character text label and a target identifier into a burst of eight 16-bit words on a stream output. A downstream label store receives the burst, and the words are built so that the store can write them straight into its label memory. Each output word carries two characters and a 3-bit slot index. Each character is squeezed to six bits by keeping its five low bits and its ASCII bit 6. Because the user side-band bit is set on every word, the store can tell these words apart from ordinary counter increments that share the same stream.

A requester loads a label through a valid/ready port. When a request is accepted, the block captures the label and the identifier. It then sends slots 0 to 7 in order and does not accept another request until the last slot has been taken. Output backpressure is honoured on every word. The requester pads labels shorter than 16 characters with ASCII spaces before it loads them.

Top module: `label_pack_tx`

## Requirements
- R1: Each accepted request produces exactly 8 output words, with slot indices 0,1,...,7 in ascending order. The first word is valid in the cycle after acceptance.
- R2: Output word layout: bits [2:0] hold the slot index k, bit 3 is zero, bits [9:4] hold the code of character 2k, and bits [15:10] hold the code of character 2k+1. Character i is taken from `req_label[8*i+7:8*i]`.
- R3: A character's 6-bit code has bits [4:0] equal to character bits [4:0] and bit 5 equal to character bit 6.
- R4: Every output word carries the captured request identifier on `out_id`, with `out_user` high.
- R5: `req_ready` stays low from the acceptance edge until the handshake of slot 7. It is high, with `out_valid` low, in the cycle that follows that handshake.
- R6: While `out_valid` is high and `out_ready` is low, `out_data`, `out_id` and `out_user` hold their values, and `out_valid` stays high.
- R7: Changes on `req_label`, `req_id` or `req_valid` during a burst have no effect on the words of that burst.
- R8: A synchronous reset, even in the middle of a burst, drops `out_valid` and raises `req_ready` in the next cycle. The next burst starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Label request valid |
| req_ready | output | 1 | Block can accept a label |
| req_id | input | ID_W | Target identifier of the label |
| req_label | input | 8*CHARS | Label text, character i in bits [8i+7:8i] |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Packed slot word |
| out_id | output | ID_W | Target identifier on the stream |
| out_user | output | 1 | Label-word marker |

## Verification
Two things can happen in the same cycle: the requester presents a new label, and the final slot of the current burst completes its handshake. The bench raises or keeps `req_valid` asserted while slot 7 waits under random backpressure, and it also changes the label inputs during the burst. A correct block finishes the current burst unchanged, with its data still coming from the captured label. It shows `req_ready` high only in the cycle after the last handshake, and it starts the next burst at slot 0 with the new label.

// File: rtl/label_pack_tx.sv
module label_pack_tx #(
  parameter int ID_W   = 8,
  parameter int CHARS  = 16,
  parameter int SLOT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ID_W-1:0]    req_id,
  input  logic [8*CHARS-1:0] req_label,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [15:0]        out_data,
  output logic [ID_W-1:0]    out_id,
  output logic               out_user
);
  localparam int SLOTS = CHARS / 2;
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic               busy;
  logic [SLOT_W-1:0]  slot;
  logic [8*CHARS-1:0] label_q;
  logic [ID_W-1:0]    id_q;
  logic [15:0]        pair;

  function automatic logic [5:0] squeeze(input logic [7:0] c);
    return {c[6], c[4:0]};
  endfunction

  wire take = req_valid && req_ready;
  wire fire = out_valid && out_ready;

  assign pair      = label_q[32'(slot) * 16 +: 16];
  assign req_ready = !busy;
  assign out_valid = busy;
  assign out_id    = id_q;
  assign out_user  = busy;
  assign out_data  = {squeeze(pair[15:8]), squeeze(pair[7:0]), 1'b0, slot};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (take) begin
      busy    <= 1'b1;
      slot    <= '0;
      label_q <= req_label;
      id_q    <= req_id;
    end else if (fire) begin
      if (slot == LAST) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + 1'b1;
      end
    end
  end
endmodule

module label_pack_tx_chk #(
  parameter int ID_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [15:0]     out_data,
  input logic [ID_W-1:0] out_id,
  input logic            out_user
);
  a_r1_first_slot_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_data[2:0] == 3'd0);

  a_r1_slot_ascends: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_data[2:0] != 3'd7 |=>
      out_valid && out_data[2:0] == $past(out_data[2:0]) + 3'd1);

  a_r2_bit3_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_data[3]);

  a_r4_user_set: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_user);

  a_r5_no_request_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);

  a_r5_free_after_last: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_data[2:0] == 3'd7 |=> req_ready && !out_valid);

  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=>
      out_valid && $stable(out_data) && $stable(out_id) && $stable(out_user));

  a_r8_reset_idle: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> !out_valid && req_ready);
endmodule

bind label_pack_tx label_pack_tx_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_id(out_id), .out_user(out_user)
);

// File: tb/label_pack_tx_bench.sv
`timescale 1ns/1ps
module label_pack_tx_bench;
  logic         clk = 0;
  logic         rst = 1;
  logic         req_valid = 0;
  logic         req_ready;
  logic [7:0]   req_id = 0;
  logic [127:0] req_label = 0;
  logic         out_valid;
  logic         out_ready = 0;
  logic [15:0]  out_data;
  logic [7:0]   out_id;
  logic         out_user;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  label_pack_tx u_label_pack_tx (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_label(req_label), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_id(out_id), .out_user(out_user)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] code6(input logic [7:0] c);
    logic [5:0] r;
    r[4:0] = c[4:0];
    r[5]   = c[6];
    return r;
  endfunction

  function automatic logic [15:0] word_exp(input logic [127:0] lab, input int k);
    logic [7:0] lo, hi;
    lo = lab[16*k +: 8];
    hi = lab[16*k+8 +: 8];
    return {code6(hi), code6(lo), 1'b0, 3'(k)};
  endfunction

  function automatic logic [127:0] rand_label();
    logic [127:0] l;
    for (int i = 0; i < 16; i++) l[8*i +: 8] = 8'(8'h20 + ($urandom % 95));
    return l;
  endfunction

  task automatic run_label(input logic [127:0] lab, input logic [7:0] id,
                           input int pct, input bit keep_req);
    int k;
    logic [15:0] pd;
    bit stalled;
    bit rdy;
    @(negedge clk);
    req_label = lab; req_id = id; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = keep_req;
    req_label = {$urandom, $urandom, $urandom, $urandom};
    req_id = 8'($urandom);
    chk(out_valid, "R1 first word after accept", 32'(out_valid), 1);
    k = 0; stalled = 0; pd = '0;
    while (k < 8 && out_valid) begin
      chk(out_data == word_exp(lab, k), "R1/R2/R3/R7 word", 32'(out_data), 32'(word_exp(lab, k)));
      chk(out_id == id && out_user, "R4 id/user", {23'd0, out_user, out_id}, {23'd0, 1'b1, id});
      chk(!req_ready, "R5 busy", 32'(req_ready), 0);
      if (stalled) chk(out_data == pd, "R6 hold", 32'(out_data), 32'(pd));
      rdy = ($urandom % 100) < pct;
      out_ready = rdy;
      if (rdy && k == 7) req_valid = 0;
      if (keep_req && !rdy) req_label = {$urandom, $urandom, $urandom, $urandom};
      pd = out_data;
      @(negedge clk);
      if (rdy) k++;
      stalled = !rdy;
    end
    out_ready = 0;
    chk(k == 8, "R1 word count", 32'(k), 8);
    chk(req_ready && !out_valid, "R5 free after slot 7", {30'd0, req_ready, out_valid}, 32'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && req_ready, "R8 reset state", {30'd0, req_ready, out_valid}, 32'd2);
    rst = 0;
    void'($urandom(32'd1234));
    run_label({16{8'h20}}, 8'h05, 100, 0);
    run_label({16{8'h7e}}, 8'hff, 100, 1);
    run_label("BLOCK_COUNTER_09", 8'h00, 30, 1);
    run_label("lower case text!", 8'h3c, 50, 0);
    // mid-burst reset
    @(negedge clk);
    req_label = rand_label(); req_id = 8'h11; req_valid = 1;
    @(negedge clk);
    req_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 1; out_ready = 0;
    @(negedge clk);
    rst = 0;
    chk(!out_valid && req_ready, "R8 reset mid burst", {30'd0, req_ready, out_valid}, 32'd2);
    for (int n = 0; n < 24; n++)
      run_label(rand_label(), 8'($urandom), 20 + ($urandom % 81), n[0]);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule